// File: doc/BRIEF.md
# Transmitter Fault Interlock Controller

This block decides whether the amplifier chain of a transmitter may be driven. It watches a group of supply status lines, a group of temperature status lines from the amplifier modules, an overload detector for reflected power (VSWR), and two operate/standby selectors. One is on the front panel and one comes from a remote control link. Every status and selector line is active low: an open (high) line means good, and a grounded (low) line means fault or standby. An unpopulated module therefore reads as healthy.

An over-temperature event is stored in a sticky latch. That latch ignores the temperature lines once they recover. Only the temperature clear pushbutton or the power-up reset removes it. A reflected-power overload is stored in a second latch. Either a local pushbutton or a remote clear line can release it. In both latches a fault that is still present overrides a clear request. All inputs are brought into the clock domain through a synchronizer chain. The two pushbuttons are also filtered so that a press must be stable for a set number of cycles before it acts. The resulting enable is sent to the drive output, the operate lamp, the remote status bit and the main supply turn-on request. Both latch states are also visible on their own outputs.

Top module: `tx_interlock`

## Requirements
- R1: After the power-up reset (rst_n low) both fault latches read 0, and with every input high the drive enable reaches 1; a later reset clears a set temperature latch.
- R2: A low on any one of the temperature status inputs sets temp_fault and forces drive_en to 0.
- R3: Once set, temp_fault stays 1 after every temperature input has returned high, until a clear is applied.
- R4: A debounced low on temp_clr_btn_l clears temp_fault when all temperature inputs are high; if a temperature input is still low during the press, the latch stays set and remains set after the press ends.
- R5: A low on vswr_trip_l sets vswr_fault, which stays 1 after the line returns high and forces drive_en to 0.
- R6: vswr_fault is cleared by a debounced low on vswr_clr_btn_l or by a low on vswr_clr_rmt_l, either one alone being enough; a trip that is still low while a clear is applied keeps the latch set.
- R7: The operate qualifier is true only when both opr_panel_l and opr_remote_l are high; a low on either one forces drive_en to 0.
- R8: drive_en is 1 exactly when every supply status input is high, temp_fault is 0, vswr_fault is 0 and the operate qualifier is true.
- R9: opr_lamp, rmt_status and supply_on_req always equal drive_en.
- R10: A pushbutton low that lasts fewer than DEB_CYCLES clock cycles after synchronization has no effect on either latch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Power-up reset, active low, asynchronous |
| supply_stat_l | input | NUM_SUPPLY | Supply status lines, high = good |
| temp_stat_l | input | NUM_TEMP | Amplifier temperature status lines, high = good |
| temp_clr_btn_l | input | 1 | Temperature clear pushbutton, low = pressed |
| vswr_trip_l | input | 1 | Reflected-power overload detect, low = overload |
| vswr_clr_btn_l | input | 1 | Local overload clear pushbutton, low = pressed |
| vswr_clr_rmt_l | input | 1 | Remote overload clear, low = clear |
| opr_panel_l | input | 1 | Front-panel selector, high = operate, low = standby |
| opr_remote_l | input | 1 | Remote selector, high = operate, low = standby |
| drive_en | output | 1 | Amplifier drive enable |
| opr_lamp | output | 1 | Operate indicator, equals drive_en |
| rmt_status | output | 1 | Operate status to remote link, equals drive_en |
| supply_on_req | output | 1 | Main supply turn-on request, equals drive_en |
| temp_fault | output | 1 | Over-temperature latch state |
| vswr_fault | output | 1 | Overload latch state |

## Verification
The bench sweeps every combination of supply and selector levels and compares all four enable outputs with an arithmetic model. A wrong gate polarity or a missing operand would show up in that sweep as an enable that is high in standby or with a failed supply. Each temperature input is faulted in turn and then released. A latch that clears automatically would read 0 after the release, and a latch that reads only one input would miss the other ones. The bench also holds a fault during a clear and sends button presses shorter than the filter window. A latch that lets the clear win would drop while the fault is still present, and a missing or short filter would let the brief press clear the latch. Each overload clear source is also applied on its own, so clear sources combined with AND instead of OR would leave the latch stuck.

// File: rtl/tx_interlock_pkg.sv
package tx_interlock_pkg;

   // Latch states of the two sticky fault stores
   typedef struct packed {
      logic temp;
      logic vswr;
   } fault_vec_t;

   // Number of single-bit control lines synchronized beside the groups
   localparam int unsigned CTRL_LINES = 6;

   // Positions of the control lines in the synchronized control word
   localparam int unsigned IDX_TEMP_BTN = 0;
   localparam int unsigned IDX_VSWR_TRIP = 1;
   localparam int unsigned IDX_VSWR_BTN = 2;
   localparam int unsigned IDX_VSWR_RMT = 3;
   localparam int unsigned IDX_OPR_PANEL = 4;
   localparam int unsigned IDX_OPR_RMT = 5;

endpackage

// File: rtl/ilk_sync.sv
module ilk_sync #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);

   if (STAGES < 2) begin : g_bad_stages
      $error("ilk_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("ilk_sync: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] chain [STAGES];

   // Idle level is high (good / released) for every line
   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain[s] <= '1;
         end else if (s == 0) begin
            chain[s] <= din;
         end else begin
            chain[s] <= chain[(s == 0) ? 0 : s - 1];
         end
      end
   end

   assign dout = chain[STAGES-1];

endmodule

// File: rtl/ilk_debounce.sv
module ilk_debounce #(
   parameter int unsigned CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);

   if (CYCLES == 0) begin : g_bypass
      assign dout = din;
   end else begin : g_filter
      localparam int unsigned CW = (CYCLES < 2) ? 1 : $clog2(CYCLES);
      localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

      logic [CW-1:0] cnt;
      logic          state;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            state <= 1'b1;
            cnt   <= '0;
         end else if (din == state) begin
            cnt <= '0;
         end else if (cnt == LAST) begin
            state <= din;
            cnt   <= '0;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end

      assign dout = state;

      // R10: the filtered level only moves toward the level seen at its input
      a_r10_follows_input: assert property (@(posedge clk) disable iff (!rst_n)
         (state != $past(state)) |-> ($past(din) == state));
   end

endmodule

// File: rtl/ilk_fault_latch.sv
module ilk_fault_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q
);

   // Set has priority over clear; power-up leaves the latch empty
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= 1'b0;
      end else if (set_i) begin
         q <= 1'b1;
      end else if (clr_i) begin
         q <= 1'b0;
      end
   end

   // R4 / R6: a present fault overrides any clear request
   a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> q);

   // R3 / R5: without a clear, a stored fault is never dropped
   a_r3_no_auto_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (q && !clr_i) |=> q);

   // R4 / R6: a clear with no fault empties the latch
   a_r6_clear_acts: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i) |=> !q);

endmodule

// File: rtl/tx_interlock.sv
module tx_interlock
   import tx_interlock_pkg::*;
#(
   parameter int unsigned NUM_SUPPLY  = 2,
   parameter int unsigned NUM_TEMP    = 4,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned DEB_CYCLES  = 1000
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_SUPPLY-1:0] supply_stat_l,
   input  logic [NUM_TEMP-1:0]   temp_stat_l,
   input  logic                  temp_clr_btn_l,
   input  logic                  vswr_trip_l,
   input  logic                  vswr_clr_btn_l,
   input  logic                  vswr_clr_rmt_l,
   input  logic                  opr_panel_l,
   input  logic                  opr_remote_l,
   output logic                  drive_en,
   output logic                  opr_lamp,
   output logic                  rmt_status,
   output logic                  supply_on_req,
   output logic                  temp_fault,
   output logic                  vswr_fault
);

   localparam int unsigned TOTAL_W = NUM_SUPPLY + NUM_TEMP + CTRL_LINES;
   localparam int unsigned TEMP_LO = CTRL_LINES;
   localparam int unsigned SUP_LO  = CTRL_LINES + NUM_TEMP;

   if (NUM_SUPPLY < 1) begin : g_bad_supply
      $error("tx_interlock: NUM_SUPPLY must be at least 1");
   end
   if (NUM_TEMP < 1) begin : g_bad_temp
      $error("tx_interlock: NUM_TEMP must be at least 1");
   end

   // ---------------- synchronizer bank ----------------
   logic [TOTAL_W-1:0]    raw_bus;
   logic [TOTAL_W-1:0]    sync_bus;
   logic [CTRL_LINES-1:0] ctrl_s;
   logic [NUM_TEMP-1:0]   temp_s;
   logic [NUM_SUPPLY-1:0] supply_s;

   always_comb begin
      raw_bus = {supply_stat_l, temp_stat_l, opr_remote_l, opr_panel_l,
                 vswr_clr_rmt_l, vswr_clr_btn_l, vswr_trip_l, temp_clr_btn_l};
   end

   ilk_sync #(.WIDTH(TOTAL_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (raw_bus),
      .dout (sync_bus)
   );

   assign ctrl_s   = sync_bus[CTRL_LINES-1:0];
   assign temp_s   = sync_bus[TEMP_LO +: NUM_TEMP];
   assign supply_s = sync_bus[SUP_LO +: NUM_SUPPLY];

   // ---------------- pushbutton filters ----------------
   logic temp_btn_f;
   logic vswr_btn_f;

   ilk_debounce #(.CYCLES(DEB_CYCLES)) u_deb_temp (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (ctrl_s[IDX_TEMP_BTN]),
      .dout (temp_btn_f)
   );

   ilk_debounce #(.CYCLES(DEB_CYCLES)) u_deb_vswr (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (ctrl_s[IDX_VSWR_BTN]),
      .dout (vswr_btn_f)
   );

   // ---------------- fault latches ----------------
   fault_vec_t flt;
   logic temp_set, temp_clr, vswr_set, vswr_clr;

   always_comb begin
      temp_set = ~&temp_s;
      temp_clr = ~temp_btn_f;
      vswr_set = ~ctrl_s[IDX_VSWR_TRIP];
      vswr_clr = ~vswr_btn_f | ~ctrl_s[IDX_VSWR_RMT];
   end

   ilk_fault_latch u_temp_latch (
      .clk  (clk),
      .rst_n(rst_n),
      .set_i(temp_set),
      .clr_i(temp_clr),
      .q    (flt.temp)
   );

   ilk_fault_latch u_vswr_latch (
      .clk  (clk),
      .rst_n(rst_n),
      .set_i(vswr_set),
      .clr_i(vswr_clr),
      .q    (flt.vswr)
   );

   // ---------------- enable combination ----------------
   logic operate_q;
   logic supply_good;
   logic enable;

   always_comb begin
      operate_q   = ctrl_s[IDX_OPR_PANEL] & ctrl_s[IDX_OPR_RMT];
      supply_good = &supply_s;
      enable      = supply_good & ~flt.temp & ~flt.vswr & operate_q;
   end

   assign drive_en      = enable;
   assign opr_lamp      = enable;
   assign rmt_status    = enable;
   assign supply_on_req = enable;
   assign temp_fault    = flt.temp;
   assign vswr_fault    = flt.vswr;

   // R8: no drive while either fault store is occupied
   a_r8_no_drive_in_fault: assert property (@(posedge clk) disable iff (!rst_n)
      drive_en |-> !(temp_fault || vswr_fault));

   // R2: a newly stored temperature fault never coincides with drive
   a_r2_trip_kills_drive: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(temp_fault) |-> !drive_en);

   // R5: a newly stored overload never coincides with drive
   a_r5_trip_kills_drive: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(vswr_fault) |-> !drive_en);

   // R7: drive implies both selectors were in operate when synchronized
   a_r7_needs_operate: assert property (@(posedge clk) disable iff (!rst_n)
      drive_en |-> (ctrl_s[IDX_OPR_PANEL] && ctrl_s[IDX_OPR_RMT]));

endmodule

// File: tb/tx_interlock_test.sv
`timescale 1ns/1ps
module tx_interlock_test;

   localparam int unsigned NS  = 2;
   localparam int unsigned NT  = 4;
   localparam int unsigned DEB = 4;
   localparam int unsigned SETTLE = 14;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NS-1:0] supply_stat_l = '1;
   logic [NT-1:0] temp_stat_l = '1;
   logic temp_clr_btn_l = 1'b1, vswr_trip_l = 1'b1, vswr_clr_btn_l = 1'b1;
   logic vswr_clr_rmt_l = 1'b1, opr_panel_l = 1'b1, opr_remote_l = 1'b1;
   logic drive_en, opr_lamp, rmt_status, supply_on_req, temp_fault, vswr_fault;

   int compared = 0;
   int mismatched = 0;
   bit exp_temp = 1'b0;
   bit exp_vswr = 1'b0;

   always #2.5 clk = ~clk;

   tx_interlock #(.NUM_SUPPLY(NS), .NUM_TEMP(NT), .SYNC_STAGES(2),
                  .DEB_CYCLES(DEB)) uut (
      .clk(clk), .rst_n(rst_n), .supply_stat_l(supply_stat_l),
      .temp_stat_l(temp_stat_l), .temp_clr_btn_l(temp_clr_btn_l),
      .vswr_trip_l(vswr_trip_l), .vswr_clr_btn_l(vswr_clr_btn_l),
      .vswr_clr_rmt_l(vswr_clr_rmt_l), .opr_panel_l(opr_panel_l),
      .opr_remote_l(opr_remote_l), .drive_en(drive_en), .opr_lamp(opr_lamp),
      .rmt_status(rmt_status), .supply_on_req(supply_on_req),
      .temp_fault(temp_fault), .vswr_fault(vswr_fault)
   );

   task automatic chk(input logic got, input logic exp, input string req);
      compared++;
      if (got !== exp) begin
         mismatched++;
         $display("FAIL %s: got %0b expected %0b at %0t", req, got, exp, $time);
      end
   endtask

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   function automatic bit model_en();
      return (&supply_stat_l) & !exp_temp & !exp_vswr & opr_panel_l & opr_remote_l;
   endfunction

   task automatic chk_all(input string req);
      chk(temp_fault, exp_temp, {req, " temp_fault"});
      chk(vswr_fault, exp_vswr, {req, " vswr_fault"});
      chk(drive_en, model_en(), {req, " drive_en"});
   endtask

   task automatic press_temp(input int n);
      temp_clr_btn_l = 1'b0; cyc(n); temp_clr_btn_l = 1'b1; cyc(SETTLE);
   endtask

   task automatic press_vswr(input int n);
      vswr_clr_btn_l = 1'b0; cyc(n); vswr_clr_btn_l = 1'b1; cyc(SETTLE);
   endtask

   task automatic trip_vswr();
      vswr_trip_l = 1'b0; cyc(3); vswr_trip_l = 1'b1; cyc(SETTLE);
      exp_vswr = 1'b1;
   endtask

   initial begin
      #(200000 * 5);
      mismatched++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      // R1: power-up state
      cyc(4);
      rst_n = 1'b1;
      cyc(SETTLE);
      chk_all("R1");
      chk(drive_en, 1'b1, "R1 enable after reset");

      // R7 R8 R9: exhaustive supply x selector sweep
      for (int v = 0; v < 16; v++) begin
         supply_stat_l = v[1:0];
         opr_panel_l   = v[2];
         opr_remote_l  = v[3];
         cyc(SETTLE);
         chk(drive_en, model_en(), "R7 R8 sweep drive_en");
         chk(opr_lamp, model_en(), "R9 opr_lamp");
         chk(rmt_status, model_en(), "R9 rmt_status");
         chk(supply_on_req, model_en(), "R9 supply_on_req");
      end
      supply_stat_l = '1; opr_panel_l = 1'b1; opr_remote_l = 1'b1;
      cyc(SETTLE);

      // R2 R3 R4 R10: each temperature input in turn
      for (int t = 0; t < int'(NT); t++) begin
         temp_stat_l = ~(NT'(1) << t);
         cyc(SETTLE);
         exp_temp = 1'b1;
         chk_all("R2");
         temp_stat_l = '1;
         cyc(SETTLE);
         chk_all("R3 no auto clear");
         press_temp(2);
         chk_all("R10 short press ignored");
         press_temp(DEB + 6);
         exp_temp = 1'b0;
         chk_all("R4 clear");
      end

      // R4: clear while fault present loses, latch still set afterwards
      temp_stat_l = 4'b1011;
      cyc(SETTLE);
      exp_temp = 1'b1;
      press_temp(DEB + 6);
      chk_all("R4 set wins");
      temp_stat_l = '1;
      cyc(SETTLE);
      chk_all("R4 held after press");
      press_temp(DEB + 6);
      exp_temp = 1'b0;
      chk_all("R4 clear after recovery");

      // R5 R6: overload latch with each clear source
      trip_vswr();
      chk_all("R5 stored");
      vswr_clr_rmt_l = 1'b0; cyc(3); vswr_clr_rmt_l = 1'b1; cyc(SETTLE);
      exp_vswr = 1'b0;
      chk_all("R6 remote clear");
      trip_vswr();
      press_vswr(2);
      chk_all("R10 short local press ignored");
      press_vswr(DEB + 6);
      exp_vswr = 1'b0;
      chk_all("R6 local clear");
      vswr_trip_l = 1'b0; vswr_clr_rmt_l = 1'b0;
      cyc(SETTLE);
      exp_vswr = 1'b1;
      chk_all("R6 set wins");
      vswr_clr_rmt_l = 1'b1; cyc(2); vswr_trip_l = 1'b1;
      cyc(SETTLE);
      chk_all("R6 held after clear");
      vswr_clr_rmt_l = 1'b0; cyc(3); vswr_clr_rmt_l = 1'b1; cyc(SETTLE);
      exp_vswr = 1'b0;
      chk_all("R6 final clear");

      // R1: reset clears a stored temperature fault
      temp_stat_l = 4'b1110;
      cyc(SETTLE);
      temp_stat_l = '1;
      exp_temp = 1'b1;
      cyc(SETTLE);
      chk_all("R1 before reset");
      rst_n = 1'b0;
      cyc(3);
      exp_temp = 1'b0;
      chk(temp_fault, 1'b0, "R1 reset clears temp");
      rst_n = 1'b1;
      cyc(SETTLE);
      chk_all("R1 after reset");

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

endmodule